// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every cycle, which hardware threads of a multithreaded core may fetch. It sees, per thread, an active bit, a status code and a queue-occupancy count. It also sees a policy select, a requested number of grants and a drain request. It answers with up to `MAX_GRANTS` grant slots. Each slot carries a valid bit and a thread index.

Three selection policies exist. Single-thread looks only at the lowest-index active thread. Round-robin scans a registered priority order and sends every granted thread to the back of that order one cycle later. Occupancy picks the eligible threads with the smallest counts. Grants are combinational from the inputs and the registered order. The only state is that order, which is a permutation of thread indices.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is eligible only when its `active_i` bit is 1 and its 3-bit status code is 0 (running), 1 (idle) or 4 (cache fill done). Codes 2, 3, 5, 6 and 7 make it ineligible.
- R2: Under round-robin (`policy_i`=1), the order is scanned from the front and eligible threads are granted in scan order. One cycle later the granted threads sit at the back of the order, in grant order. The other threads keep their relative order. After reset the order is 0,1,...,N-1. The order changes only after a round-robin cycle with at least one grant.
- R3: Under single-thread (`policy_i`=0), only the lowest-index active thread is considered. It is granted in slot 0 if it is eligible; otherwise nothing is granted. There is never more than one grant.
- R4: Under occupancy (`policy_i`=2), slot 0 gets the eligible thread with the smallest `occ_i` count, with ties going to the lower index. Each further slot repeats the rule among the threads not yet granted.
- R5: The number of grants is the smaller of `want_i`, `MAX_GRANTS` and the number of eligible threads. Slots fill from slot 0 upward, and no thread appears in two slots.
- R6: When no thread is eligible, every `valid_o` bit is 0.
- R7: While `drain_i` is 1, no slot is valid and the round-robin order does not change.
- R8: `policy_i`=3 behaves exactly like single-thread.
- R9: With `NTHREADS`=1, the block uses the single-thread policy whatever `policy_i` says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_i | input | NTHREADS | Per-thread active bit |
| status_i | input | NTHREADS*3 | Per-thread status code, thread i at bits [3i+2:3i] |
| policy_i | input | 2 | 0 single, 1 round-robin, 2 occupancy, 3 as single |
| occ_i | input | NTHREADS*OCC_W | Per-thread occupancy count, thread i at [OCC_W*i +: OCC_W] |
| want_i | input | REQ_W | Number of grants requested this cycle |
| drain_i | input | 1 | Suppresses all grants |
| valid_o | output | MAX_GRANTS | Per-slot grant valid |
| tid_o | output | MAX_GRANTS*IDX_W | Per-slot thread index, slot k at [IDX_W*k +: IDX_W] |

## Verification
The hardest case to reach is a round-robin order that has been rotated far from its reset value. This includes runs where two grants in one cycle move a pair to the back together, and runs where drain or other policies were interleaved, during which the order must not move. Random stimulus switches policies, request counts and drain over thousands of cycles, and the bench keeps its own model of the order. The order is never read directly; it shows up only through the indices of later round-robin grants. Directed cases pin down the rotation right after reset, occupancy ties, a single-thread front thread that is not eligible, and the one-thread configuration.

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int NTHREADS   = 4,
  parameter int MAX_GRANTS = 2,
  parameter int OCC_W      = 6,
  localparam int STAT_W    = 3,
  localparam int IDX_W     = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int REQ_W     = $clog2(MAX_GRANTS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NTHREADS-1:0]           active_i,
  input  logic [NTHREADS*STAT_W-1:0]    status_i,
  input  logic [1:0]                    policy_i,
  input  logic [NTHREADS*OCC_W-1:0]     occ_i,
  input  logic [REQ_W-1:0]              want_i,
  input  logic                          drain_i,
  output logic [MAX_GRANTS-1:0]         valid_o,
  output logic [MAX_GRANTS*IDX_W-1:0]   tid_o
);

  localparam logic [1:0] POL_RR  = 2'd1;
  localparam logic [1:0] POL_OCC = 2'd2;

  logic [NTHREADS-1:0] elig;
  logic [1:0]          mode;
  int                  lim;

  logic [IDX_W-1:0] order_q [NTHREADS];
  logic [IDX_W-1:0] order_d [NTHREADS];
  logic [IDX_W-1:0] gtid    [MAX_GRANTS];
  logic [MAX_GRANTS-1:0] gval;
  logic [NTHREADS-1:0]   taken;

  for (genvar i = 0; i < NTHREADS; i++) begin : g_elig
    logic [STAT_W-1:0] st;
    assign st = status_i[i*STAT_W +: STAT_W];
    assign elig[i] = active_i[i] & ((st == 3'd0) | (st == 3'd1) | (st == 3'd4));
  end

  if (NTHREADS > 1) begin : g_multi
    assign mode = policy_i;
  end else begin : g_one
    assign mode = 2'd0;
  end

  assign lim = drain_i ? 0 :
               ((int'(want_i) > MAX_GRANTS) ? MAX_GRANTS : int'(want_i));

  always_comb begin
    int cnt;
    int first;
    int best;
    gval  = '0;
    taken = '0;
    for (int k = 0; k < MAX_GRANTS; k++) gtid[k] = '0;
    cnt   = 0;
    first = -1;
    best  = -1;
    case (mode)
      POL_RR: begin
        for (int p = 0; p < NTHREADS; p++) begin
          if (elig[order_q[p]] && cnt < lim) begin
            gval[cnt] = 1'b1;
            gtid[cnt] = order_q[p];
            taken[order_q[p]] = 1'b1;
            cnt = cnt + 1;
          end
        end
      end
      POL_OCC: begin
        for (int k = 0; k < MAX_GRANTS; k++) begin
          best = -1;
          if (k < lim) begin
            for (int i = 0; i < NTHREADS; i++) begin
              if (elig[i] && !taken[i]) begin
                if (best < 0)
                  best = i;
                else if (occ_i[i*OCC_W +: OCC_W] < occ_i[best*OCC_W +: OCC_W])
                  best = i;
              end
            end
          end
          if (best >= 0) begin
            gval[cnt] = 1'b1;
            gtid[cnt] = IDX_W'(best);
            taken[best] = 1'b1;
            cnt = cnt + 1;
          end
        end
      end
      default: begin
        for (int i = NTHREADS - 1; i >= 0; i--)
          if (active_i[i]) first = i;
        if (first >= 0 && lim > 0 && elig[first]) begin
          gval[0] = 1'b1;
          gtid[0] = IDX_W'(first);
        end
      end
    endcase
  end

  for (genvar k = 0; k < MAX_GRANTS; k++) begin : g_out
    assign valid_o[k] = gval[k];
    assign tid_o[k*IDX_W +: IDX_W] = gtid[k];
  end

  always_comb begin
    int n;
    for (int p = 0; p < NTHREADS; p++) order_d[p] = order_q[p];
    n = 0;
    if (mode == POL_RR && gval != '0) begin
      for (int p = 0; p < NTHREADS; p++) begin
        if (!taken[order_q[p]] && n < NTHREADS) begin
          order_d[n] = order_q[p];
          n = n + 1;
        end
      end
      for (int k = 0; k < MAX_GRANTS; k++) begin
        if (gval[k] && n < NTHREADS) begin
          order_d[n] = gtid[k];
          n = n + 1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NTHREADS; p++) order_q[p] <= IDX_W'(p);
    end else begin
      for (int p = 0; p < NTHREADS; p++) order_q[p] <= order_d[p];
    end
  end

  logic [NTHREADS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int p = 0; p < NTHREADS; p++) seen[order_q[p]] = 1'b1;
  end

  // R2
  perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == NTHREADS);

  // R7
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |-> valid_o == '0);

  // R5
  grant_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_o) <= int'(want_i));

  // R3
  single_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != POL_RR && mode != POL_OCC) |-> $countones(valid_o) <= 1);

  // R6
  none_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> valid_o == '0);

  for (genvar k = 0; k < MAX_GRANTS; k++) begin : g_slot_chk
    // R1
    slot_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o[k] |-> elig[tid_o[k*IDX_W +: IDX_W]]);
    if (k > 0) begin : g_fill
      // R5
      slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o[k] |-> valid_o[k-1]);
    end
    for (genvar j = k + 1; j < MAX_GRANTS; j++) begin : g_dup
      // R5
      slot_uniq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o[k] && valid_o[j]) |->
          tid_o[k*IDX_W +: IDX_W] != tid_o[j*IDX_W +: IDX_W]);
    end
  end

  for (genvar i = 0; i < NTHREADS; i++) begin : g_occ_chk
    // R4
    occ_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == POL_OCC && valid_o[0] && elig[i]) |->
        occ_i[i*OCC_W +: OCC_W] >= occ_i[int'(tid_o[IDX_W-1:0])*OCC_W +: OCC_W]);
  end

endmodule

// File: tb/tb_fetch_thread_sel.sv
module tb_fetch_thread_sel;
  localparam int N = 4;
  localparam int MG = 2;
  localparam int OW = 6;
  localparam int IW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] active;
  logic [N*3-1:0] status;
  logic [1:0] policy;
  logic [N*OW-1:0] occ;
  logic [1:0] want;
  logic drain;
  logic [MG-1:0] valid;
  logic [MG*IW-1:0] tid;

  logic a1;
  logic [2:0] s1;
  logic [1:0] v1;
  logic [1:0] t1;

  int checks = 0;
  int errors = 0;
  int mo [N];
  int nmo [N];
  int ev [MG];
  int et [MG];

  always #2 clk = ~clk;

  fetch_thread_sel #(.NTHREADS(N), .MAX_GRANTS(MG), .OCC_W(OW)) dut (
    .clk(clk), .rst_n(rst_n), .active_i(active), .status_i(status),
    .policy_i(policy), .occ_i(occ), .want_i(want), .drain_i(drain),
    .valid_o(valid), .tid_o(tid));

  fetch_thread_sel #(.NTHREADS(1), .MAX_GRANTS(MG), .OCC_W(OW)) dut_one (
    .clk(clk), .rst_n(rst_n), .active_i(a1), .status_i(s1),
    .policy_i(policy), .occ_i(occ[OW-1:0]), .want_i(want), .drain_i(drain),
    .valid_o(v1), .tid_o(t1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_elig(int i);
    int s;
    s = int'(status[i*3 +: 3]);
    return active[i] && (s == 0 || s == 1 || s == 4);
  endfunction

  task automatic model();
    int lim, cnt, best, first, n;
    bit tk [N];
    for (int k = 0; k < MG; k++) begin ev[k] = 0; et[k] = 0; end
    for (int i = 0; i < N; i++) begin tk[i] = 0; nmo[i] = mo[i]; end
    lim = drain ? 0 : ((int'(want) > MG) ? MG : int'(want));
    cnt = 0;
    if (policy == 2'd1) begin
      for (int p = 0; p < N; p++)
        if (is_elig(mo[p]) && cnt < lim) begin
          ev[cnt] = 1; et[cnt] = mo[p]; tk[mo[p]] = 1; cnt++;
        end
      if (cnt > 0) begin
        n = 0;
        for (int p = 0; p < N; p++) if (!tk[mo[p]]) begin nmo[n] = mo[p]; n++; end
        for (int k = 0; k < cnt; k++) begin nmo[n] = et[k]; n++; end
      end
    end else if (policy == 2'd2) begin
      for (int k = 0; k < lim; k++) begin
        best = -1;
        for (int i = 0; i < N; i++)
          if (is_elig(i) && !tk[i] &&
              (best < 0 || occ[i*OW +: OW] < occ[best*OW +: OW])) best = i;
        if (best >= 0) begin ev[cnt] = 1; et[cnt] = best; tk[best] = 1; cnt++; end
      end
    end else begin
      first = -1;
      for (int i = N - 1; i >= 0; i--) if (active[i]) first = i;
      if (first >= 0 && lim > 0 && is_elig(first)) begin ev[0] = 1; et[0] = first; end
    end
  endtask

  task automatic compare(input string req);
    model();
    for (int k = 0; k < MG; k++) begin
      chk(int'(valid[k]) == ev[k], req, int'(valid[k]), ev[k]);
      if (ev[k] == 1)
        chk(int'(tid[k*IW +: IW]) == et[k], req, int'(tid[k*IW +: IW]), et[k]);
    end
  endtask

  task automatic set_all(input logic [N-1:0] act, input int st, input logic [1:0] pol,
                         input logic [1:0] w, input logic dr);
    active = act;
    for (int i = 0; i < N; i++) status[i*3 +: 3] = 3'(st);
    policy = pol; want = w; drain = dr;
  endtask

  task automatic finish_cycle();
    @(posedge clk);
    for (int i = 0; i < N; i++) mo[i] = nmo[i];
    @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) mo[i] = i;
    set_all('1, 0, 2'd1, 2'd1, 1'b0);
    occ = '0; a1 = 1; s1 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R2: reset order grants thread 0 first
    chk(valid[0] == 1 && tid[1:0] == 0, "R2 reset order", int'(tid[1:0]), 0);
    compare("R2");
    finish_cycle();
    for (int c = 0; c < 4; c++) begin
      #1;
      // R2 rotation 1,2,3,0
      chk(int'(tid[1:0]) == (c + 1) % N, "R2 rotate", int'(tid[1:0]), (c + 1) % N);
      compare("R2");
      finish_cycle();
    end
    // R7: drain blocks grants and keeps order
    set_all('1, 0, 2'd1, 2'd2, 1'b1);
    #1;
    chk(valid == 0, "R7 drain", int'(valid), 0);
    compare("R7");
    finish_cycle();
    set_all('1, 0, 2'd1, 2'd1, 1'b0);
    #1;
    chk(int'(tid[1:0]) == 1, "R7 order kept", int'(tid[1:0]), 1);
    compare("R7");
    finish_cycle();
    // R5: two grants, clipped request
    set_all('1, 0, 2'd1, 2'd3, 1'b0);
    #1;
    chk(valid == 2'b11, "R5 clip", int'(valid), 3);
    compare("R5");
    finish_cycle();
    // R1: blocked statuses ineligible, code 4 eligible
    set_all('1, 2, 2'd2, 2'd2, 1'b0);
    status[2*3 +: 3] = 3'd4;
    occ = '0;
    #1;
    chk(valid == 2'b01 && tid[1:0] == 2, "R1 status", int'(tid[1:0]), 2);
    compare("R1");
    finish_cycle();
    // R6: nothing eligible
    set_all('1, 5, 2'd1, 2'd2, 1'b0);
    #1;
    chk(valid == 0, "R6 none", int'(valid), 0);
    compare("R6");
    finish_cycle();
    // R4: tie on smallest count goes to lower index
    set_all('1, 0, 2'd2, 2'd2, 1'b0);
    occ = {6'd3, 6'd1, 6'd1, 6'd7};
    #1;
    chk(tid[1:0] == 1 && tid[3:2] == 2, "R4 tie", int'(tid), 9);
    compare("R4");
    finish_cycle();
    // R3: front active thread ineligible means no grant
    set_all(4'b1110, 0, 2'd0, 2'd2, 1'b0);
    status[1*3 +: 3] = 3'd3;
    #1;
    chk(valid == 0, "R3 front blocked", int'(valid), 0);
    compare("R3");
    finish_cycle();
    // R8: reserved code acts as single
    set_all(4'b1100, 1, 2'd3, 2'd2, 1'b0);
    #1;
    chk(valid == 2'b01 && tid[1:0] == 2, "R8 reserved", int'(tid[1:0]), 2);
    compare("R8");
    finish_cycle();
    // R9: one-thread configuration
    set_all('1, 0, 2'd1, 2'd2, 1'b0);
    a1 = 1; s1 = 3'd4;
    #1;
    chk(v1 == 2'b01 && t1 == 0, "R9 one thread", int'(v1), 1);
    compare("R2");
    finish_cycle();
    a1 = 1; s1 = 3'd6; policy = 2'd2;
    #1;
    chk(v1 == 0, "R9 one thread blocked", int'(v1), 0);
    compare("R4");
    finish_cycle();
    for (int it = 0; it < 4000; it++) begin
      policy = 2'($urandom % 4);
      active = 4'($urandom);
      for (int i = 0; i < N; i++) status[i*3 +: 3] = 3'($urandom % 6);
      for (int i = 0; i < N; i++) occ[i*OW +: OW] = 6'($urandom % 8);
      want = 2'($urandom);
      drain = ($urandom % 8) == 0;
      #1;
      if (drain) compare("R7");
      else if (policy == 2'd1) compare("R2");
      else if (policy == 2'd2) compare("R4");
      else compare("R3");
      finish_cycle();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule